// File: doc/BRIEF.md
# Power-Management Event Interrupt Aggregator

This block gathers up to 32 single-bit event strobes from a power-management unit into a pending-event register. A second register holds one enable bit for each source. Every source that is both pending and enabled contributes to a single level-sensitive interrupt line that goes to a parent interrupt controller. Software reaches both registers through a simple single-cycle register port. A write takes effect at the clock edge. A read is combinational from the address.

The pending register is plain read/write. Each bit takes exactly the value that software writes into it, so writing a 1 raises that source by hand. To clear a serviced source, software reads the register and writes it back with that bit cleared. A strobe that arrives in the same cycle as such a write still lands, so no event is lost in that window. The block also reports the highest-numbered source that is pending and enabled, with a valid flag. A handler can use this to work through sources from the top down.

Top module: `pmu_irq_agg`

## Requirements
- R1: After reset, the pending register and the enable register both read as zero, `irq_o` is low and `top_vld_o` is low.
- R2: A write to byte offset 0x50 loads the pending register with exactly the written value. A 1 bit sets that source and a 0 bit clears it. A read at 0x50 returns the value held.
- R3: A write to byte offset 0x54 loads the enable register with the written value, and a read at 0x54 returns it.
- R4: An `evt_i` bit that is high at a clock edge sets the matching pending bit. The bit stays set until software writes a 0 into it.
- R5: When an `evt_i` bit is high in the same cycle as a write to 0x50, the matching pending bit ends up set, whatever value was written.
- R6: `irq_o` is high in every cycle in which some bit is set in both the pending register and the enable register, and low otherwise.
- R7: A pending bit whose enable bit is 0 does not raise `irq_o`, but it is still returned unmasked by a read of 0x50.
- R8: `top_idx_o` gives the highest bit index set in both the pending and enable registers, and `top_vld_o` is then high. When no such bit exists, `top_vld_o` is low and `top_idx_o` is 0.
- R9: A read of any offset other than 0x50 or 0x54 returns zero. A write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event strobes, one per source |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write enable for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt to the parent controller |
| top_idx_o | output | 5 | Highest pending, enabled source index |
| top_vld_o | output | 1 | `top_idx_o` is meaningful |

## Verification
Corrupted pending or enable state shows up at the ports in the cycle right after the edge that stored it. It appears as a wrong read value at 0x50 or 0x54, and also as a wrong `irq_o` level or a wrong `top_idx_o`, because all three outputs are combinational from the two registers. A lost event in a strobe/write collision is visible on the very next read of 0x50. A priority error appears only when more than one source is pending and enabled. For that reason the bench sets several bits spread across the range, including bit 31 and bit 0.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;

    // Byte offsets decoded by software drivers
    localparam logic [15:0] PEND_OFS = 16'h0050;
    localparam logic [15:0] ENAB_OFS = 16'h0054;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_ENAB = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [15:0] addr);
        if (addr == PEND_OFS)      return SEL_PEND;
        else if (addr == ENAB_OFS) return SEL_ENAB;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/pmu_irq_regs.sv
module pmu_irq_regs
    import pmu_irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               pend_we_i,
    input  logic               enab_we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enab_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] enab_q;

    // One cell per source: a hardware strobe outranks a software write
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[g] <= 1'b0;
            else if (evt_i[g])
                pend_q[g] <= 1'b1;
            else if (pend_we_i)
                pend_q[g] <= wdata_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            enab_q <= '0;
        else if (enab_we_i)
            enab_q <= wdata_i;
    end

    assign pend_o = pend_q;
    assign enab_o = enab_q;

endmodule

// File: rtl/pmu_irq_prio.sv
module pmu_irq_prio #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               vld_o
);

    // Ascending scan: the last hit is the highest index
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_i[i]) begin
                idx_o = IDX_W'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pmu_irq_agg.sv
module pmu_irq_agg
    import pmu_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   top_idx_o,
    output logic               top_vld_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] enab_w;
    logic [NUM_SRC-1:0] act_w;

    assign sel = decode_sel(16'(bus_addr_i));

    pmu_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .pend_we_i (bus_we_i && sel == SEL_PEND),
        .enab_we_i (bus_we_i && sel == SEL_ENAB),
        .wdata_i   (bus_wdata_i),
        .pend_o    (pend_w),
        .enab_o    (enab_w)
    );

    assign act_w = pend_w & enab_w;
    assign irq_o = |act_w;

    pmu_irq_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .act_i (act_w),
        .idx_o (top_idx_o),
        .vld_o (top_vld_o)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND: bus_rdata_o = pend_w;
            SEL_ENAB: bus_rdata_o = enab_w;
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pmu_irq_agg_chk.sv
module pmu_irq_agg_chk
    import pmu_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt,
    input logic [ADDR_W-1:0]  addr,
    input logic               we,
    input logic [NUM_SRC-1:0] wdata,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] enab,
    input logic               irq,
    input logic [IDX_W-1:0]   idx,
    input logic               vld
);

    // R2
    pend_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && decode_sel(16'(addr)) == SEL_PEND && evt == '0) |=> pend == $past(wdata));

    // R3
    enab_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && decode_sel(16'(addr)) == SEL_ENAB) |=> enab == $past(wdata));

    // R4
    evt_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(we && decode_sel(16'(addr)) != SEL_NONE) && evt == '0) |=> ($stable(pend) && $stable(enab)));

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == vld);

    // R8
    top_exact_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> (((pend & enab) >> idx) == NUM_SRC'(1)));

    // R8
    none_idx_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> (idx == '0 && (pend & enab) == '0));

endmodule

bind pmu_irq_agg pmu_irq_agg_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt_i),
    .addr  (bus_addr_i),
    .we    (bus_we_i),
    .wdata (bus_wdata_i),
    .pend  (pend_w),
    .enab  (enab_w),
    .irq   (irq_o),
    .idx   (top_idx_o),
    .vld   (top_vld_o)
);

// File: tb/pmu_irq_agg_bench.sv
module pmu_irq_agg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam logic [7:0] A_PEND = 8'h50;
    localparam logic [7:0] A_ENAB = 8'h54;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] evt = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [NS-1:0] wdata = '0;
    logic [NS-1:0] rdata;
    logic          irq;
    logic [4:0]    idx;
    logic          vld;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_irq_agg u_pmu_irq_agg (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .top_idx_o   (idx),
        .top_vld_o   (vld)
    );

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            report();
        end
    end

    task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [NS-1:0] d, input logic [NS-1:0] e);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; evt = e;
        @(negedge clk);
        we = 1'b0; evt = '0;
    endtask

    task automatic strobe(input logic [NS-1:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [NS-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [NS-1:0] v;
        rd(A_PEND, v); check("R1 pend", v, '0);
        rd(A_ENAB, v); check("R1 enab", v, '0);
        check("R1 irq", NS'(irq), '0);
        check("R1 vld", NS'(vld), '0);
    endtask

    task automatic t_regs;
        logic [NS-1:0] v;
        wr(A_PEND, 32'hA5A5_0F0F, '0);
        rd(A_PEND, v); check("R2 set", v, 32'hA5A5_0F0F);
        wr(A_PEND, 32'h0000_0F00, '0);
        rd(A_PEND, v); check("R2 clear", v, 32'h0000_0F00);
        wr(A_ENAB, 32'h1234_5678, '0);
        rd(A_ENAB, v); check("R3", v, 32'h1234_5678);
        wr(A_PEND, '0, '0);
        wr(A_ENAB, '0, '0);
    endtask

    task automatic t_events;
        logic [NS-1:0] v;
        strobe(32'h0000_0008);
        strobe(32'h0001_0000);
        rd(A_PEND, v); check("R4 sticky", v, 32'h0001_0008);
        check("R7 masked irq", NS'(irq), '0);
        wr(A_PEND, 32'h0001_0000, '0);
        rd(A_PEND, v); check("R4 rmw clear", v, 32'h0001_0000);
        wr(A_PEND, 32'h0000_0000, 32'h0000_0020);
        rd(A_PEND, v); check("R5 collision", v, 32'h0000_0020);
        wr(A_PEND, '0, '0);
    endtask

    task automatic t_prio;
        wr(A_ENAB, 32'hFFFF_FFFF, '0);
        wr(A_PEND, 32'h0001_0009, '0);
        #1;
        check("R6 irq", NS'(irq), 1);
        check("R8 idx16", NS'({vld, idx}), NS'({1'b1, 5'd16}));
        wr(A_ENAB, 32'h0000_FFFF, '0);
        #1;
        check("R8 idx3", NS'({vld, idx}), NS'({1'b1, 5'd3}));
        wr(A_ENAB, 32'hFFFF_FFFF, '0);
        wr(A_PEND, 32'h8000_0001, '0);
        #1;
        check("R8 idx31", NS'({vld, idx}), NS'({1'b1, 5'd31}));
        wr(A_ENAB, 32'h0000_0000, '0);
        #1;
        check("R7 irq off", NS'(irq), '0);
        check("R8 none", NS'({vld, idx}), '0);
    endtask

    task automatic t_other;
        logic [NS-1:0] v;
        wr(A_ENAB, 32'h0000_00F0, '0);
        wr(8'h58, 32'hFFFF_FFFF, '0);
        wr(8'h51, 32'hFFFF_FFFF, '0);
        rd(8'h58, v); check("R9 read other", v, '0);
        rd(A_PEND, v); check("R9 pend kept", v, 32'h8000_0001);
        rd(A_ENAB, v); check("R9 enab kept", v, 32'h0000_00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_events();
        t_prio();
        t_other();
        report();
    end

endmodule